// File: doc/BRIEF.md
# Three-Wire Serial Register Slave for a Display Driver

This block sits on the peripheral side of a display driver. It gives a host controller access to a small set of configuration registers over a serial bus with three wires: an active-low chip select, a serial clock and one shared data line. The shared line is split at the block's edge into a receive input, a transmit output and a tristate enable, so the pad stays outside the block. All bus inputs are brought into the block's system clock domain and their edges are detected there. The serial clock must therefore be several times slower than the system clock.

Each frame starts with a header. The header carries a 6-bit register address and a direction bit.
- A write header is 8 bits long, ending in a padding bit, and is followed by a data byte.
- A read header is 7 bits long. It is followed by one clock in which nobody drives the line, and then the block drives back the 8 bits of the register.

The registers are:
- a scratch register for link testing;
- a read-only identification byte;
- a resolution code;
- a power/ownership register.

The block exports the resolution code and the active/standby state to the display logic. These two values come either from the register fields or from strap pins, depending on one ownership bit.

Top module: `tw_spi_regslave`

## Requirements
- R1: While chip select is low, the master shifts bits in on rising serial-clock edges. Frame bits 1 to 6 are the register address, MSB first. Bit 7 is the direction: 1 reads, 0 writes.
- R2: In a write frame, bit 8 is padding and its value has no effect. Bits 9 to 16 are the data byte, MSB first. The byte is stored into the addressed register after the 16th rising edge.
- R3: In a read frame, the 8th clock is a turnaround in which the data-out enable stays low. The enable is high only for the 8 data clocks that follow. Each data bit, MSB first, is launched after a falling edge and stays stable through the next high phase. The enable drops after the falling edge that follows the 16th rising edge.
- R4: Address 0x00 is a scratch register. Any byte written there reads back unchanged.
- R5: Address 0x01 is read-only. It returns the chip ID in bits [7:4] (default 0x3) and the version in bits [3:0] (default 0x1); writes to it are ignored.
- R6: Address 0x02 stores a full byte, and bits [2:0] are the resolution code: 7 = 800x480, 6 = 640x480, 5 = 480x272, 4 = 480x640, 1 = dual-scan 480x272, 0 = dual-scan 400x240.
- R7: Address 0x03 stores a full byte. Bit 0 is the power state (1 active, 0 standby) and bit 7 is the owner (1 registers, 0 straps). When bit 7 is 1, the exported resolution and active outputs follow register 0x02 bits [2:0] and register 0x03 bit 0. When bit 7 is 0, they follow the strap inputs.
- R8: While the active-low reset is low, the registers hold their defaults: scratch 0x00, resolution register 0x07, power register 0x00. The data-out enable is low.
- R9: Raising chip select at any point abandons the frame. An unfinished write changes no register, the data-out enable drops, and the next frame starts from bit 1.
- R10: Addresses 0x04 to 0x3F read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Receive side of the shared data line |
| spi_sdo | output | 1 | Transmit side of the shared data line |
| spi_sdo_oe | output | 1 | Tristate enable for the shared data line |
| strap_res | input | 3 | Strap-selected resolution code |
| strap_active | input | 1 | Strap-selected power state, 1 = active |
| res_code | output | 3 | Exported resolution code |
| panel_active | output | 1 | Exported power state, 1 = active |

## Verification
The bench sweeps all 64 addresses with an address-dependent write and then reads every one of them back. This separates the four decoded registers, the read-only byte and the unmapped space, and any bit-order slip in the address would land data in the wrong place. The scratch register is exercised with forty spread values with the padding bit toggled between frames, which catches shift-order errors and any effect of padding. Every read frame probes the enable through the turnaround and across each data bit's high phase. Strap codes are swept under both ownership settings, and frames are cut short at several bit positions to show that an abort commits nothing.

// File: rtl/tw_spi_pkg.sv
package tw_spi_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int HDR_BITS   = ADDR_W + 2;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int RES_W      = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [RES_W-1:0]  res_t;

    // bit-counter values at which the frame engine acts
    localparam cnt_t CNT_ADDR_LAST = cnt_t'(ADDR_W - 1);
    localparam cnt_t CNT_DIR       = cnt_t'(ADDR_W);
    localparam cnt_t CNT_TX_FIRST  = cnt_t'(HDR_BITS);
    localparam cnt_t CNT_LAST_BIT  = cnt_t'(FRAME_BITS - 1);
    localparam cnt_t CNT_DONE      = cnt_t'(FRAME_BITS);

    typedef enum logic [ADDR_W-1:0] {
        SEL_SCRATCH = 6'h00,
        SEL_IDENT   = 6'h01,
        SEL_FORMAT  = 6'h02,
        SEL_POWER   = 6'h03
    } reg_sel_e;

    localparam int PWR_ON_BIT    = 0;
    localparam int PWR_OWNER_BIT = 7;

    // one write strobe leaving the frame engine
    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    // synchronised bus pins
    typedef struct packed {
        logic csn;
        logic sck;
        logic sdi;
    } bus_pins_t;

    localparam bus_pins_t BUS_IDLE = '{csn: 1'b1, sck: 1'b0, sdi: 1'b0};

    function automatic logic in_tx_window(input cnt_t c, input logic rd);
        return rd && (c >= CNT_TX_FIRST) && (c < CNT_DONE);
    endfunction

endpackage

// File: rtl/tw_spi_sync.sv
module tw_spi_sync
    import tw_spi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  bus_pins_t pins_i,
    output bus_pins_t pins_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    bus_pins_t stg [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N; s++) stg[s] <= BUS_IDLE;
        end else begin
            stg[0] <= pins_i;
            for (int s = 1; s < N; s++) stg[s] <= stg[s-1];
        end
    end

    assign pins_o = stg[N-1];

endmodule

// File: rtl/tw_spi_frame.sv
module tw_spi_frame
    import tw_spi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_pins_t bus_i,
    input  byte_t     rd_data,
    output addr_t     rd_addr,
    output wr_req_t   wr_req,
    output logic      sdo,
    output logic      sdo_oe
);
    logic  sck_d;
    logic  sck_rise;
    logic  sck_fall;
    cnt_t  cnt;
    byte_t shin;
    byte_t txsh;
    addr_t addr_q;
    logic  is_rd;

    assign sck_rise = bus_i.sck & ~sck_d;
    assign sck_fall = ~bus_i.sck & sck_d;
    assign rd_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            cnt    <= '0;
            shin   <= '0;
            txsh   <= '0;
            addr_q <= '0;
            is_rd  <= 1'b0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            wr_req <= '0;
        end else begin
            sck_d     <= bus_i.sck;
            wr_req.en <= 1'b0;
            if (bus_i.csn) begin
                cnt    <= '0;
                is_rd  <= 1'b0;
                sdo    <= 1'b0;
                sdo_oe <= 1'b0;
            end else begin
                if (sck_rise) begin
                    if (cnt != CNT_DONE) cnt <= cnt + cnt_t'(1);
                    shin <= {shin[DATA_W-2:0], bus_i.sdi};
                    if (cnt == CNT_ADDR_LAST)
                        addr_q <= {shin[ADDR_W-2:0], bus_i.sdi};
                    if (cnt == CNT_DIR) begin
                        is_rd <= bus_i.sdi;
                        if (bus_i.sdi) txsh <= rd_data;
                    end
                    if (cnt == CNT_LAST_BIT && !is_rd) begin
                        wr_req.en   <= 1'b1;
                        wr_req.addr <= addr_q;
                        wr_req.data <= {shin[DATA_W-2:0], bus_i.sdi};
                    end
                end
                if (sck_fall) begin
                    if (in_tx_window(cnt, is_rd)) begin
                        sdo_oe <= 1'b1;
                        sdo    <= txsh[DATA_W-1];
                        txsh   <= {txsh[DATA_W-2:0], 1'b0};
                    end else begin
                        sdo_oe <= 1'b0;
                        sdo    <= 1'b0;
                    end
                end
            end
        end
    end

    // R3
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (is_rd && cnt >= CNT_TX_FIRST));

    // R3
    oe_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sck_fall));

    // R9
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_i.csn |=> !sdo_oe);

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req.en |=> !wr_req.en);

endmodule

// File: rtl/tw_spi_regs.sv
module tw_spi_regs
    import tw_spi_pkg::*;
#(
    parameter logic [3:0] CHIP_ID   = 4'h3,
    parameter logic [3:0] CHIP_VER  = 4'h1,
    parameter res_t       RES_RESET = 3'd7
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wr_req_t wr_req,
    input  addr_t   rd_addr,
    output byte_t   rd_data,
    input  res_t    strap_res,
    input  logic    strap_active,
    output res_t    res_code,
    output logic    panel_active
);
    localparam byte_t IDENT_BYTE  = {CHIP_ID, CHIP_VER};
    localparam byte_t FORMAT_INIT = byte_t'(RES_RESET);

    byte_t scratch_q;
    byte_t format_q;
    byte_t power_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            format_q  <= FORMAT_INIT;
            power_q   <= '0;
        end else if (wr_req.en) begin
            case (reg_sel_e'(wr_req.addr))
                SEL_SCRATCH: scratch_q <= wr_req.data;
                SEL_FORMAT:  format_q  <= wr_req.data;
                SEL_POWER:   power_q   <= wr_req.data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_SCRATCH: rd_data = scratch_q;
            SEL_IDENT:   rd_data = IDENT_BYTE;
            SEL_FORMAT:  rd_data = format_q;
            SEL_POWER:   rd_data = power_q;
            default:     rd_data = '0;
        endcase
    end

    always_comb begin
        if (power_q[PWR_OWNER_BIT]) begin
            res_code     = format_q[RES_W-1:0];
            panel_active = power_q[PWR_ON_BIT];
        end else begin
            res_code     = strap_res;
            panel_active = strap_active;
        end
    end

    // R4
    scratch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req.en && wr_req.addr == SEL_SCRATCH) |=> $stable(scratch_q));

    // R6
    format_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req.en && wr_req.addr == SEL_FORMAT) |=> $stable(format_q));

endmodule

// File: rtl/tw_spi_regslave.sv
module tw_spi_regslave
    import tw_spi_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] CHIP_ID     = 4'h3,
    parameter logic [3:0] CHIP_VER    = 4'h1,
    parameter logic [2:0] RES_RESET   = 3'd7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic       spi_sdi,
    output logic       spi_sdo,
    output logic       spi_sdo_oe,
    input  logic [2:0] strap_res,
    input  logic       strap_active,
    output logic [2:0] res_code,
    output logic       panel_active
);
    bus_pins_t pins_raw;
    bus_pins_t pins_s;
    wr_req_t   wr_req;
    addr_t     rd_addr;
    byte_t     rd_data;

    assign pins_raw = '{csn: spi_csn, sck: spi_sck, sdi: spi_sdi};

    tw_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_raw),
        .pins_o (pins_s)
    );

    tw_spi_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_i   (pins_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_req  (wr_req),
        .sdo     (spi_sdo),
        .sdo_oe  (spi_sdo_oe)
    );

    tw_spi_regs #(
        .CHIP_ID   (CHIP_ID),
        .CHIP_VER  (CHIP_VER),
        .RES_RESET (RES_RESET)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .strap_res    (strap_res),
        .strap_active (strap_active),
        .res_code     (res_code),
        .panel_active (panel_active)
    );

endmodule

// File: tb/tb_tw_spi_regslave.sv
module tb_tw_spi_regslave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] IDENT = 8'h31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1;
    logic sck = 1'b0;
    logic m_drv = 1'b0;
    logic m_bit = 1'b0;
    logic sdo, oe;
    logic [2:0] s_res = 3'd5;
    logic s_act = 1'b0;
    logic [2:0] res_code;
    logic panel_active;
    wire  line = m_drv ? m_bit : (oe ? sdo : 1'b1);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_spi_regslave dut (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_sdi(line),
        .spi_sdo(sdo), .spi_sdo_oe(oe), .strap_res(s_res), .strap_active(s_act),
        .res_code(res_code), .panel_active(panel_active)
    );

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic spi_write(input logic [5:0] a, input logic [7:0] d,
                             input logic pad, input int cut);
        logic [15:0] fr;
        fr = {a, 1'b0, pad, d};
        csn = 1'b0;
        half();
        for (int i = 0; i < 16; i++) begin
            if (i >= cut) break;
            m_drv = 1'b1;
            m_bit = fr[15-i];
            half();
            sck = 1'b1;
            half();
            sck = 1'b0;
        end
        half();
        csn = 1'b1;
        m_drv = 1'b0;
        repeat (3) half();
    endtask

    task automatic spi_read(input logic [5:0] a, output logic [7:0] d, input int cut);
        logic [6:0] hd;
        logic b;
        hd = {a, 1'b1};
        d = '0;
        b = 1'b0;
        csn = 1'b0;
        half();
        for (int i = 0; i < 16; i++) begin
            if (i >= cut) break;
            if (i < 7) begin
                m_drv = 1'b1;
                m_bit = hd[6-i];
            end else begin
                m_drv = 1'b0;
            end
            half();
            if (i == 7) check("R3", "turnaround enable", 32'(oe), 32'd0);
            if (i >= 8) begin
                b = line;
                check("R3", "data enable", 32'(oe), 32'd1);
                d[15-i] = b;
            end
            sck = 1'b1;
            half();
            if (i >= 8) check("R3", "bit held through high phase", 32'(line), 32'(b));
            sck = 1'b0;
        end
        half();
        if (cut >= 16) check("R3", "enable after last bit", 32'(oe), 32'd0);
        csn = 1'b1;
        m_drv = 1'b0;
        repeat (3) half();
        check("R9", "enable after chip select high", 32'(oe), 32'd0);
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R8", "enable in reset", 32'(oe), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] v;
        logic [7:0] exp;

        // reset state
        pulse_reset();
        check("R8", "res_code from strap after reset", 32'(res_code), 32'd5);
        check("R8", "active from strap after reset", 32'(panel_active), 32'd0);
        spi_read(6'h00, rv, 16); check("R8", "scratch default", 32'(rv), 32'h00);
        spi_read(6'h01, rv, 16); check("R5", "ident byte", 32'(rv), 32'(IDENT));
        spi_read(6'h02, rv, 16); check("R8", "format default", 32'(rv), 32'h07);
        spi_read(6'h03, rv, 16); check("R8", "power default", 32'(rv), 32'h00);

        // strap sweep with owner bit clear
        for (int c = 0; c < 16; c++) begin
            s_res = 3'(c);
            s_act = c[3];
            repeat (2) @(negedge clk);
            check("R7", "strap res", 32'(res_code), 32'(c & 7));
            check("R7", "strap active", 32'(panel_active), 32'(c[3]));
        end

        // scratch sweep, padding toggled
        for (int k = 0; k < 40; k++) begin
            v = 8'((k * 37 + 11) % 256);
            spi_write(6'h00, v, k[0], 16);
            spi_read(6'h00, rv, 16);
            check((k[0] ? "R2" : "R4"), "scratch readback", 32'(rv), 32'(v));
        end

        // read-only ident
        spi_write(6'h01, 8'hFF, 1'b0, 16);
        spi_read(6'h01, rv, 16);
        check("R5", "ident after write", 32'(rv), 32'(IDENT));

        // full address sweep
        for (int a = 0; a < 64; a++) begin
            model[a] = 8'((a * 7 + 8'h80) % 256);
            spi_write(6'(a), model[a], 1'b1, 16);
        end
        for (int a = 0; a < 64; a++) begin
            spi_read(6'(a), rv, 16);
            if (a == 0 || a == 2 || a == 3) exp = model[a];
            else if (a == 1) exp = IDENT;
            else exp = 8'h00;
            check((a < 4) ? "R1" : "R10", "address sweep", 32'(rv), 32'(exp));
        end

        // register ownership
        spi_write(6'h02, 8'hF8, 1'b0, 16);
        spi_write(6'h03, 8'h80, 1'b0, 16);
        check("R7", "owned active", 32'(panel_active), 32'd0);
        for (int c = 0; c < 8; c++) begin
            spi_write(6'h02, 8'(8'hA0 | c), 1'b0, 16);
            check("R6", "owned res code", 32'(res_code), 32'(c));
        end
        spi_read(6'h02, rv, 16);
        check("R6", "format full byte", 32'(rv), 32'hA7);
        spi_write(6'h03, 8'h81, 1'b0, 16);
        check("R7", "owned active set", 32'(panel_active), 32'd1);
        s_res = 3'd2;
        s_act = 1'b0;
        repeat (2) @(negedge clk);
        check("R7", "straps ignored when owned", 32'(res_code), 32'd7);
        check("R7", "strap active ignored when owned", 32'(panel_active), 32'd1);
        spi_write(6'h03, 8'h01, 1'b0, 16);
        check("R7", "straps back", 32'(res_code), 32'd2);
        check("R7", "strap active back", 32'(panel_active), 32'd0);

        // aborted frames
        spi_write(6'h00, 8'h3C, 1'b0, 16);
        spi_write(6'h00, 8'hC3, 1'b0, 12);
        spi_read(6'h00, rv, 16);
        check("R9", "write cut at 12", 32'(rv), 32'h3C);
        spi_write(6'h00, 8'hC3, 1'b0, 15);
        spi_read(6'h00, rv, 16);
        check("R9", "write cut at 15", 32'(rv), 32'h3C);
        spi_read(6'h00, rv, 11);
        spi_read(6'h00, rv, 16);
        check("R9", "read after cut read", 32'(rv), 32'h3C);

        // reset mid-run
        spi_write(6'h03, 8'h81, 1'b0, 16);
        pulse_reset();
        check("R8", "strap res after reset", 32'(res_code), 32'd2);
        spi_read(6'h00, rv, 16); check("R8", "scratch after reset", 32'(rv), 32'h00);
        spi_read(6'h02, rv, 16); check("R8", "format after reset", 32'(rv), 32'h07);
        spi_read(6'h03, rv, 16); check("R8", "power after reset", 32'(rv), 32'h00);

        done = 1;
        finish_run();
    end

endmodule